// File: doc/BRIEF.md
# Ready-Handshake Memory Bus Slave

This block is a small memory target on a simple processor bus. The master drives a one-way address bus and the read, write and size control lines. Data travels in both directions. Since the block cannot model a true tristate pin, the data bus is split into three ports: an input lane, an output lane and an output enable. The slave marks the end of every transfer with a one-clock ready pulse.

Storage is a 16-row by 8-bit array. It is built from eight one-bit-wide column slices that are accessed side by side, and each slice supplies one bit of the byte. Row decoders turn the address into a one-hot row select. The size line chooses between a byte transfer on the low lane of a 16-bit data path and a word transfer that covers an even/odd row pair. A parameter adds wait states to model slow storage. A master that asserts read and write together is answered with an empty, zero-data acknowledge.

Top module: `membus_slave`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ready and data_oe are 0 and data_out is 0.
- R2: A byte transfer (size = 0) writes data_in[7:0] to the row given by the full 4-bit address. A later byte read of that row returns the byte on data_out[7:0], with data_out[15:8] at 0.
- R3: A word transfer (size = 1) ignores address bit 0. It uses row {addr[3:1],0} for data[7:0] and row {addr[3:1],1} for data[15:8], for both reads and writes.
- R4: Ready rises exactly WAIT_CYCLES clock edges after the edge that first samples read or write high in the idle state, and it stays low before that.
- R5: Ready is high for exactly one clock per transfer.
- R6: After the acknowledge, holding read or write high starts no new transfer. The next transfer is accepted only after both have been seen low.
- R7: data_oe is high only in the acknowledge cycle of a read (or of the dual-strobe case in R8), and data_out is 0 whenever data_oe is low. A write acknowledge has data_oe at 0.
- R8: When read and write are both high, the block acknowledges with the normal latency, drives data_out as 0 with data_oe high, and stores nothing.
- R9: A byte write leaves every other row unchanged, including the other row of its even/odd pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (4) | Row address from the master |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| size | input | 1 | 0 = byte on the low lane, 1 = word over an even/odd row pair |
| data_in | input | 2*LANE_W (16) | Write data lane of the data bus |
| data_out | output | 2*LANE_W (16) | Read data lane, 0 when not driven |
| data_oe | output | 1 | High while the slave drives read data |
| ready | output | 1 | One-clock completion pulse |

## Verification
The array is first filled with distinct word writes, so that any wrong row select or swapped lane shows up as a wrong value and not as a zero. Byte reads at even and odd rows, after a word write to an odd address, show whether address bit 0 is dropped for words and kept for bytes. Byte writes into one half of a pair, followed by word reads, show that writes do not spill into the neighbouring row. A dual-strobe request followed by a read-back separates "acknowledged and discarded" from "silently stored". Every transfer also measures the edge on which ready rises and holds the strobes past the acknowledge, which catches off-by-one wait counts and re-triggering.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_HOLD
  } hs_state_t;

  localparam logic SZ_BYTE = 1'b0;
  localparam logic SZ_WORD = 1'b1;
endpackage

// File: rtl/mbs_row_decoder.sv
module mbs_row_decoder #(
  parameter int ADDR_W = 4,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] row,
  input  logic              en,
  output logic [ROWS-1:0]   sel
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign sel[i] = en && (row == ADDR_W'(i));
  end
endmodule

// File: rtl/mbs_bit_slice.sv
module mbs_bit_slice #(
  parameter int ROWS = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [ROWS-1:0] sel_lo,
  input  logic [ROWS-1:0] sel_hi,
  input  logic            d_lo,
  input  logic            d_hi,
  output logic            q_lo,
  output logic            q_hi
);
  logic [ROWS-1:0] cells;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROWS; i++) begin
      if (we && sel_lo[i])
        cells[i] <= d_lo;
      else if (we && sel_hi[i])
        cells[i] <= d_hi;
    end
  end

  assign q_lo = |(cells & sel_lo);
  assign q_hi = |(cells & sel_hi);
endmodule

// File: rtl/mbs_handshake.sv
module mbs_handshake
  import mbs_pkg::*;
#(
  parameter int WAIT_CYCLES = 2,
  localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic wr,
  output logic start,
  output logic fire,
  output logic ready
);
  hs_state_t        state;
  logic [CNT_W-1:0] cnt;

  assign start = (state == ST_IDLE) && (rd || wr);
  assign fire  = (state == ST_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      ready <= fire;
      case (state)
        ST_IDLE: if (rd || wr) begin
          state <= ST_WAIT;
          cnt   <= CNT_W'(WAIT_CYCLES - 1);
        end
        ST_WAIT: if (cnt == '0) state <= ST_ACK;
                 else cnt <= cnt - 1'b1;
        ST_ACK:  state <= ST_HOLD;
        default: if (!rd && !wr) state <= ST_IDLE;
      endcase
    end
  end

  // R4: ready can only rise out of the wait phase
  a_r4_rise_from_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(state) == ST_WAIT);
  // R6: a held strobe after the acknowledge never restarts the wait
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && (rd || wr)) |=> state == ST_HOLD);
endmodule

// File: rtl/membus_slave.sv
module membus_slave
  import mbs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LANE_W      = 8,
  parameter int WAIT_CYCLES = 2,
  localparam int ROWS   = 1 << ADDR_W,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              size,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ready
);
  logic              start, fire;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_size, cap_rd, cap_wr;
  logic [DATA_W-1:0] cap_data;
  logic [ADDR_W-1:0] row_lo, row_hi;
  logic [ROWS-1:0]   sel_lo, sel_hi;
  logic [LANE_W-1:0] q_lo, q_hi;
  logic              array_we;

  mbs_handshake #(.WAIT_CYCLES(WAIT_CYCLES)) u_hs (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr),
    .start(start), .fire(fire), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_size <= SZ_BYTE;
      cap_data <= '0;
      cap_rd   <= 1'b0;
      cap_wr   <= 1'b0;
    end else if (start) begin
      cap_addr <= addr;
      cap_size <= size;
      cap_data <= data_in;
      cap_rd   <= rd && !wr;
      cap_wr   <= wr && !rd;
    end
  end

  assign row_lo   = (cap_size == SZ_WORD) ? {cap_addr[ADDR_W-1:1], 1'b0} : cap_addr;
  assign row_hi   = {cap_addr[ADDR_W-1:1], 1'b1};
  assign array_we = fire && cap_wr;

  mbs_row_decoder #(.ADDR_W(ADDR_W)) u_dec_lo (
    .row(row_lo), .en(1'b1), .sel(sel_lo)
  );
  mbs_row_decoder #(.ADDR_W(ADDR_W)) u_dec_hi (
    .row(row_hi), .en(cap_size == SZ_WORD), .sel(sel_hi)
  );

  for (genvar b = 0; b < LANE_W; b++) begin : g_slice
    mbs_bit_slice #(.ROWS(ROWS)) u_slice (
      .clk(clk), .we(array_we), .sel_lo(sel_lo), .sel_hi(sel_hi),
      .d_lo(cap_data[b]), .d_hi(cap_data[LANE_W+b]),
      .q_lo(q_lo[b]), .q_hi(q_hi[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else if (fire && !cap_wr) begin
      data_oe  <= 1'b1;
      data_out <= cap_rd ? {q_hi, q_lo} : '0;
    end else begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end
  end

  // R5: single-clock acknowledge
  a_r5_ready_one_clock: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R7: the data lane is only driven during an acknowledge
  a_r7_oe_only_on_ack: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ready);
  a_r7_released_zero: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == '0);
  // R8: dual strobe returns zero data
  a_r8_dual_zero: assert property (@(posedge clk) disable iff (rst)
    (ready && rd && wr) |-> data_out == '0);
  // R3: each decoder selects at most one row
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_lo) && $onehot0(sel_hi));
endmodule

// File: tb/sim_membus_slave.sv
`timescale 1ns/1ps
module sim_membus_slave;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0, size = 1'b0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        data_oe, ready;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  membus_slave #(.WAIT_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .size(size),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock invariants (R5, R7)
  logic prev_ready = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ready && prev_ready) chk("R5 ready two clocks", 1, 0);
      if (!data_oe && data_out != 0) chk("R7 released lane nonzero", {16'h0, data_out}, 0);
      if (data_oe && !ready) chk("R7 oe without ready", 1, 0);
    end
    prev_ready = ready;
  end

  task automatic xfer(input logic r, input logic w, input logic sz,
                      input logic [3:0] a, input logic [15:0] wd, input string tag);
    logic [15:0] exp_d;
    logic        exp_oe;
    logic [3:0]  lo_row;
    lo_row = sz ? {a[3:1], 1'b0} : a;
    exp_oe = r;
    if (r && !w) exp_d = sz ? {model[lo_row + 1], model[lo_row]} : {8'h00, model[lo_row]};
    else exp_d = 16'h0;
    @(negedge clk);
    addr = a; rd = r; wr = w; size = sz; data_in = wd;
    for (int i = 1; i <= W + 1; i++) begin
      @(negedge clk);
      if (i <= W) chk({"R4 early ready ", tag}, {31'h0, ready}, 0);
      else        chk({"R4 ready on time ", tag}, {31'h0, ready}, 1);
    end
    chk({"R7 oe ", tag}, {31'h0, data_oe}, {31'h0, exp_oe});
    chk({"data ", tag}, {16'h0, data_out}, {16'h0, exp_d});
    if (w && !r) begin
      if (sz) begin model[lo_row] = wd[7:0]; model[lo_row + 1] = wd[15:8]; end
      else model[a] = wd[7:0];
    end
    @(negedge clk);
    chk({"R5 ready dropped ", tag}, {31'h0, ready}, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({"R6 no re-trigger ", tag}, {31'h0, ready}, 0);
    end
    rd = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", {31'h0, ready}, 0);
    chk("R1 oe in reset", {31'h0, data_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'h0, ready}, 0);
    chk("R1 data after reset", {16'h0, data_out}, 0);

    // fill the array with word writes (R3)
    for (int p = 0; p < 8; p++)
      xfer(0, 1, 1, 4'(2 * p), {8'(8'h91 + 16 * p), 8'(8'h1E + 16 * p)}, "R3 fill");
    for (int p = 0; p < 8; p++)
      xfer(1, 0, 1, 4'(2 * p + 1), 16'h0, "R3 word read odd addr");

    // byte write then read, low lane only (R2)
    xfer(0, 1, 0, 4'd3, 16'hFFA5, "R2 byte write");
    xfer(1, 0, 0, 4'd3, 16'h0, "R2 byte read");
    // neighbour in pair untouched (R9)
    xfer(1, 0, 0, 4'd2, 16'h0, "R9 neighbour row");
    xfer(0, 1, 0, 4'd8, 16'h003C, "R9 byte write even");
    xfer(1, 0, 1, 4'd8, 16'h0, "R9 pair after byte write");
    xfer(1, 0, 0, 4'd9, 16'h0, "R9 odd row unchanged");

    // word write at odd address (R3)
    xfer(0, 1, 1, 4'd7, 16'hBEEF, "R3 word write odd addr");
    xfer(1, 0, 0, 4'd6, 16'h0, "R3 even byte of word");
    xfer(1, 0, 0, 4'd7, 16'h0, "R3 odd byte of word");
    xfer(1, 0, 1, 4'd6, 16'h0, "R3 word read even addr");

    // dual strobe (R8)
    xfer(1, 1, 1, 4'd6, 16'h1234, "R8 dual strobe");
    xfer(1, 0, 1, 4'd6, 16'h0, "R8 nothing stored");
    xfer(1, 1, 0, 4'd3, 16'h0077, "R8 dual strobe byte");
    xfer(1, 0, 0, 4'd3, 16'h0, "R8 byte kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule